// File: doc/BRIEF.md
# DSP-Mode Stereo Audio Serial Receiver

This block is a clock-slave receiver for a frame-pulse serial audio link. A bit clock, a word clock and one serial data line arrive from an external master and are sampled by the block's own system clock. Each frame opens with a word-clock pulse. After a programmable number of bit periods, the left-channel word and then, with no gap, the right-channel word are shifted in MSB first. Once the last right-channel bit has been taken, both words come out together, right-justified in 32-bit outputs, with a one-cycle valid strobe.

The word length, the start offset and the bit-clock edge used for sampling are all programmable. The block counts bit periods between successive frame pulses and checks the programmed word length and offset against that measured length. An impossible setting raises a sticky error flag and withholds that frame's samples. Bits that follow the right word are dropped. A frame pulse that arrives in the middle of a word abandons the frame.

Top module: `dsp_serial_rx`

## Requirements
- R1: While reset is held and in the first cycle after it, sample_valid, cfg_error, left_sample, right_sample and frame_bits are all zero.
- R2: cfg_wlen selects the word length N: code 0 gives 16 bits, 1 gives 20, 2 gives 24, 3 gives 32. Each word is received MSB first, from bit N-1 down to bit 0, and is presented right-justified with bits 31..N zero.
- R3: Bit period 0 of a frame is the one whose sampling edge first sees the word clock high after it was low. The left MSB is taken in bit period cfg_offset, so an offset of 0 takes it together with the frame pulse.
- R4: The right word's MSB is taken in the bit period right after the left word's LSB (period cfg_offset+N). No extra word-clock edge is needed.
- R5: With cfg_bclk_inv = 0, data and word clock are sampled on rising bit-clock edges. With cfg_bclk_inv = 1 they are sampled on falling edges.
- R6: sample_valid is a single system-clock pulse, issued at most once per frame after the final right bit. left_sample and right_sample change only together with that pulse.
- R7: frame_bits gives the number of bit periods between the two most recent frame pulses.
- R8: At each frame pulse that has a measured length, the setting is illegal when frame_bits < 2N or cfg_offset + N > frame_bits. An illegal setting sets cfg_error, which stays set until reset, and the frame that begins at that pulse produces no sample_valid. A later legal frame produces samples again while cfg_error stays set.
- R9: The first frame after reset has no measured length. It produces no sample_valid and does not set cfg_error.
- R10: Data bits after the right word's LSB and before the next frame pulse have no effect on the outputs.
- R11: A frame pulse that arrives before the right word is complete abandons the frame in progress, so that frame produces no sample_valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wlen | input | 2 | Word-length code (0:16, 1:20, 2:24, 3:32) |
| cfg_offset | input | 8 | Bit periods from the frame pulse to the left MSB |
| cfg_bclk_inv | input | 1 | 0 samples on rising bit-clock edges, 1 on falling edges |
| ser_bclk | input | 1 | Serial bit clock from the master |
| ser_wclk | input | 1 | Frame-pulse word clock from the master |
| ser_data | input | 1 | Serial audio data |
| left_sample | output | 32 | Last received left word, right-justified |
| right_sample | output | 32 | Last received right word, right-justified |
| sample_valid | output | 1 | One-cycle strobe marking a new sample pair |
| cfg_error | output | 1 | Sticky flag for an illegal length/offset setting |
| frame_bits | output | 10 | Measured bit periods in the previous frame |

## Verification
The bench sweeps every word-length code over several offsets in both bit-clock polarities. It fills the bits after the right word with ones, so a design that cuts the word at the wrong place, shifts by one bit, or lets the trailing bits in returns sums that differ from the computed values. Sampling on the wrong edge moves each word by one bit period, and a missing back-to-back handoff corrupts the right word. A truncated frame checks that a mid-word pulse gives no strobe. Frames whose previous length breaks either the 2N rule or the offset rule check that the flag is set and stays set, and that the strobe is withheld only for the offending frame. A design that reports a sample for the unmeasured first frame, or that mismeasures the frame length, shows up in the strobe count and in frame_bits.

// File: rtl/dspr_pkg.sv
package dspr_pkg;

    localparam int SAMPLE_W = 32;
    localparam int OFF_W    = 8;
    localparam int WCODE_W  = 2;
    localparam int NBITS_W  = 7;

    typedef enum logic [WCODE_W-1:0] {
        WLEN_16 = 2'd0,
        WLEN_20 = 2'd1,
        WLEN_24 = 2'd2,
        WLEN_32 = 2'd3
    } wlen_code_e;

    // word length in bits for a length code
    function automatic logic [NBITS_W-1:0] wlen_bits(input logic [WCODE_W-1:0] code);
        logic [NBITS_W-1:0] n;
        case (wlen_code_e'(code))
            WLEN_16: n = 7'd16;
            WLEN_20: n = 7'd20;
            WLEN_24: n = 7'd24;
            default: n = 7'd32;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/dspr_edge_sync.sv
module dspr_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_in,
    input  logic wclk_in,
    input  logic data_in,
    input  logic invert,
    output logic bit_stb,
    output logic wclk_smp,
    output logic data_smp
);

    typedef struct packed {
        logic [SYNC_STAGES:0]   bclk;
        logic [SYNC_STAGES-1:0] wclk;
        logic [SYNC_STAGES-1:0] data;
    } sync_t;

    sync_t sync_d, sync_q;
    logic  newest, older;

    always_comb begin
        sync_d      = sync_q;
        sync_d.bclk = {sync_q.bclk[SYNC_STAGES-1:0], bclk_in};
        sync_d.wclk = {sync_q.wclk[SYNC_STAGES-2:0], wclk_in};
        sync_d.data = {sync_q.data[SYNC_STAGES-2:0], data_in};

        newest   = sync_q.bclk[SYNC_STAGES-1];
        older    = sync_q.bclk[SYNC_STAGES];
        bit_stb  = invert ? (older & ~newest) : (newest & ~older);
        wclk_smp = sync_q.wclk[SYNC_STAGES-1];
        data_smp = sync_q.data[SYNC_STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

endmodule

// File: rtl/dspr_frame_ctrl.sv
module dspr_frame_ctrl
    import dspr_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_stb,
    input  logic               wclk_smp,
    input  logic [WCODE_W-1:0] cfg_wlen,
    input  logic [OFF_W-1:0]   cfg_offset,
    output logic               frame_start,
    output logic               shift_left,
    output logic               shift_right,
    output logic               last_bit,
    output logic               frame_legal,
    output logic [CNT_W-1:0]   frame_len,
    output logic               cfg_error
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] pos;
        logic [CNT_W-1:0] flen;
        logic             wclk_prev;
        logic             seen;
        logic             active;
        logic             legal;
        logic             err;
    } fctl_t;

    fctl_t q, d;

    logic [CNT_W-1:0] n_ext, off_ext, cur, lo_r, hi;
    logic             start, act, legal_new;

    always_comb begin
        d       = q;
        n_ext   = CNT_W'(wlen_bits(cfg_wlen));
        off_ext = CNT_W'(cfg_offset);
        lo_r    = off_ext + n_ext;
        hi      = lo_r + n_ext;

        start     = bit_stb & wclk_smp & ~q.wclk_prev;
        cur       = start ? '0 : q.pos;
        act       = start | q.active;
        legal_new = (q.pos >= (n_ext << 1)) && (lo_r <= q.pos);

        if (bit_stb) begin
            d.wclk_prev = wclk_smp;
            if (start) begin
                d.pos    = ONE;
                d.active = 1'b1;
                d.seen   = 1'b1;
                if (q.seen) begin
                    d.flen  = q.pos;
                    d.legal = legal_new;
                    d.err   = q.err | ~legal_new;
                end else begin
                    d.legal = 1'b0;
                end
            end else if (q.pos != CNT_MAX) begin
                d.pos = q.pos + ONE;
            end
        end

        shift_left  = bit_stb & act & (cur >= off_ext) & (cur < lo_r);
        shift_right = bit_stb & act & (cur >= lo_r) & (cur < hi);
        last_bit    = bit_stb & act & (cur == hi - ONE);
        if (last_bit) d.active = 1'b0;

        frame_start = start;
        frame_legal = start ? d.legal : q.legal;
        frame_len   = q.flen;
        cfg_error   = q.err;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/dspr_word_capture.sv
module dspr_word_capture
    import dspr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_start,
    input  logic                shift_left,
    input  logic                shift_right,
    input  logic                last_bit,
    input  logic                frame_legal,
    input  logic                data_bit,
    output logic [SAMPLE_W-1:0] left_out,
    output logic [SAMPLE_W-1:0] right_out,
    output logic                valid_out
);

    typedef struct packed {
        logic [SAMPLE_W-1:0] shl;
        logic [SAMPLE_W-1:0] shr;
        logic [SAMPLE_W-1:0] left;
        logic [SAMPLE_W-1:0] right;
        logic                valid;
    } cap_t;

    cap_t q, d;

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        if (frame_start) begin
            d.shl = '0;
            d.shr = '0;
        end
        if (shift_left)  d.shl = {d.shl[SAMPLE_W-2:0], data_bit};
        if (shift_right) d.shr = {d.shr[SAMPLE_W-2:0], data_bit};
        if (last_bit && frame_legal) begin
            d.left  = d.shl;
            d.right = d.shr;
            d.valid = 1'b1;
        end
        left_out  = q.left;
        right_out = q.right;
        valid_out = q.valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/dsp_serial_rx.sv
module dsp_serial_rx
    import dspr_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [WCODE_W-1:0]  cfg_wlen,
    input  logic [OFF_W-1:0]    cfg_offset,
    input  logic                cfg_bclk_inv,
    input  logic                ser_bclk,
    input  logic                ser_wclk,
    input  logic                ser_data,
    output logic [SAMPLE_W-1:0] left_sample,
    output logic [SAMPLE_W-1:0] right_sample,
    output logic                sample_valid,
    output logic                cfg_error,
    output logic [CNT_W-1:0]    frame_bits
);

    logic bit_stb, wclk_smp, data_smp;
    logic frame_start, shift_left, shift_right, last_bit, frame_legal;

    dspr_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .bclk_in  (ser_bclk),
        .wclk_in  (ser_wclk),
        .data_in  (ser_data),
        .invert   (cfg_bclk_inv),
        .bit_stb  (bit_stb),
        .wclk_smp (wclk_smp),
        .data_smp (data_smp)
    );

    dspr_frame_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_stb     (bit_stb),
        .wclk_smp    (wclk_smp),
        .cfg_wlen    (cfg_wlen),
        .cfg_offset  (cfg_offset),
        .frame_start (frame_start),
        .shift_left  (shift_left),
        .shift_right (shift_right),
        .last_bit    (last_bit),
        .frame_legal (frame_legal),
        .frame_len   (frame_bits),
        .cfg_error   (cfg_error)
    );

    dspr_word_capture u_cap (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .shift_left  (shift_left),
        .shift_right (shift_right),
        .last_bit    (last_bit),
        .frame_legal (frame_legal),
        .data_bit    (data_smp),
        .left_out    (left_sample),
        .right_out   (right_sample),
        .valid_out   (sample_valid)
    );

endmodule

// File: rtl/dspr_rx_checker.sv
module dspr_rx_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  cfg_wlen,
    input logic [31:0] left_sample,
    input logic [31:0] right_sample,
    input logic        sample_valid,
    input logic        cfg_error
);

    p_valid_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> !sample_valid)
        else $error("sample_valid held longer than one cycle");

    p_hold_between_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |-> ($stable(left_sample) && $stable(right_sample)))
        else $error("samples changed without a strobe");

    p_error_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_error |=> cfg_error)
        else $error("cfg_error cleared without reset");

    p_error_rise_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_error) |-> !sample_valid)
        else $error("strobe together with a new configuration error");

    p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && cfg_wlen == 2'd0) |-> (left_sample[31:16] == 16'h0 && right_sample[31:16] == 16'h0))
        else $error("16-bit word not right-justified");

endmodule

bind dsp_serial_rx dspr_rx_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_wlen     (cfg_wlen),
    .left_sample  (left_sample),
    .right_sample (right_sample),
    .sample_valid (sample_valid),
    .cfg_error    (cfg_error)
);

// File: tb/dsp_serial_rx_test.sv
`timescale 1ns/1ps
module dsp_serial_rx_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_wlen = 2'd0;
    logic [7:0]  cfg_offset = 8'd0;
    logic        cfg_bclk_inv = 1'b0;
    logic        ser_bclk = 1'b0;
    logic        ser_wclk = 1'b0;
    logic        ser_data = 1'b0;
    logic [31:0] left_sample, right_sample;
    logic        sample_valid, cfg_error;
    logic [9:0]  frame_bits;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    int vcount = 0;
    logic [31:0] got_l = '0, got_r = '0;

    always #2 clk = ~clk;

    dsp_serial_rx uut (
        .clk(clk), .rst_n(rst_n), .cfg_wlen(cfg_wlen), .cfg_offset(cfg_offset),
        .cfg_bclk_inv(cfg_bclk_inv), .ser_bclk(ser_bclk), .ser_wclk(ser_wclk),
        .ser_data(ser_data), .left_sample(left_sample), .right_sample(right_sample),
        .sample_valid(sample_valid), .cfg_error(cfg_error), .frame_bits(frame_bits)
    );

    always @(negedge clk) begin
        if (rst_n && sample_valid) begin
            vcount = vcount + 1;
            got_l  = left_sample;
            got_r  = right_sample;
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 190000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run did not finish, got %0d cycles expected fewer", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks = checks + 1;
        if (got !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic int nbits(input logic [1:0] code);
        return (code == 2'd0) ? 16 : (code == 2'd1) ? 20 : (code == 2'd2) ? 24 : 32;
    endfunction

    function automatic logic [31:0] wmask(input int n);
        return (n == 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
    endfunction

    function automatic logic [31:0] pat(input int k);
        return (32'h9E37_79B9 * (k + 1)) ^ (32'(k) << 7) ^ 32'h5A5A_0C3F;
    endfunction

    task automatic set_cfg(input logic [1:0] wl, input logic [7:0] off, input logic inv);
        @(negedge clk);
        cfg_wlen = wl;
        cfg_offset = off;
        cfg_bclk_inv = inv;
        repeat (3) @(negedge clk);
        ser_bclk = inv;
        repeat (4) @(negedge clk);
    endtask

    // one frame of flen bit periods; bits outside the two words are ones
    task automatic send_frame(input int flen, input int off, input int n,
                              input logic [31:0] l, input logic [31:0] r);
        for (int i = 0; i < flen; i++) begin
            int idx;
            idx = i - off;
            ser_wclk = (i == 0);
            if (idx >= 0 && idx < n)          ser_data = l[n-1-idx];
            else if (idx >= n && idx < 2 * n) ser_data = r[2*n-1-idx];
            else                              ser_data = 1'b1;
            repeat (4) @(negedge clk);
            ser_bclk = ~cfg_bclk_inv;
            repeat (4) @(negedge clk);
            ser_bclk = cfg_bclk_inv;
        end
        ser_wclk = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R1 valid in reset", {31'b0, sample_valid}, 32'h0);
        check("R1 error in reset", {31'b0, cfg_error}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 left after reset", left_sample, 32'h0);
        check("R1 right after reset", right_sample, 32'h0);
        check("R1 frame_bits after reset", {22'b0, frame_bits}, 32'h0);
    endtask

    initial begin
        int k;
        k = 0;
        repeat (3) @(negedge clk);
        do_reset();

        // R9: first frame after reset
        set_cfg(2'd0, 8'd0, 1'b0);
        vcount = 0;
        send_frame(80, 0, 16, 32'h1234, 32'hABCD);
        check("R9 no strobe on first frame", 32'(vcount), 32'd0);
        check("R9 no error on first frame", {31'b0, cfg_error}, 32'h0);

        // sweep: polarity x word length x offset, frame length 80
        for (int inv = 0; inv < 2; inv++) begin
            for (int wl = 0; wl < 4; wl++) begin
                for (int oi = 0; oi < 4; oi++) begin
                    int off, n;
                    logic [31:0] el, er;
                    string tg;
                    off = (oi == 0) ? 0 : (oi == 1) ? 1 : (oi == 2) ? 3 : 7;
                    n = nbits(2'(wl));
                    el = pat(k) & wmask(n);
                    er = pat(k + 500) & wmask(n);
                    k++;
                    set_cfg(2'(wl), 8'(off), inv[0]);
                    vcount = 0;
                    send_frame(80, off, n, el, er);
                    tg = inv ? "R5 falling-edge" : "R3 rising-edge";
                    check({"R6 strobe count ", tg}, 32'(vcount), 32'd1);
                    check({"R2 left word ", tg}, got_l, el);
                    check({"R4 R10 right word ", tg}, got_r, er);
                    check({"R8 no error legal ", tg}, {31'b0, cfg_error}, 32'h0);
                end
            end
        end
        check("R7 frame_bits 80", {22'b0, frame_bits}, 32'd80);

        // R7: longer frame measured at the following pulse
        set_cfg(2'd1, 8'd2, 1'b0);
        vcount = 0;
        send_frame(100, 2, 20, 32'h000A_5A5A, 32'h0003_C3C3);
        send_frame(80, 2, 20, 32'h0001_1111, 32'h000E_EEEE);
        check("R7 frame_bits 100", {22'b0, frame_bits}, 32'd100);
        check("R6 two strobes", 32'(vcount), 32'd2);

        // R11: pulse arrives inside the right word
        set_cfg(2'd0, 8'd0, 1'b0);
        vcount = 0;
        send_frame(20, 0, 16, 32'h0000_F00D, 32'h0000_BEEF);
        check("R11 aborted frame no strobe", 32'(vcount), 32'd0);
        check("R11 error not yet set", {31'b0, cfg_error}, 32'h0);

        // R8: previous length 20 < 2N
        vcount = 0;
        send_frame(80, 0, 16, 32'h0000_1357, 32'h0000_2468);
        check("R8 short frame sets error", {31'b0, cfg_error}, 32'h1);
        check("R8 strobe withheld", 32'(vcount), 32'd0);
        check("R7 frame_bits 20", {22'b0, frame_bits}, 32'd20);

        // R8: sticky error, legal frame produces again
        vcount = 0;
        send_frame(80, 0, 16, 32'h0000_7777, 32'h0000_8888);
        check("R8 error stays", {31'b0, cfg_error}, 32'h1);
        check("R8 legal frame strobes", 32'(vcount), 32'd1);
        check("R8 legal left", got_l, 32'h0000_7777);

        // R8: offset rule, reset then previous length 80 with offset 60, N 32
        do_reset();
        set_cfg(2'd3, 8'd60, 1'b0);
        vcount = 0;
        send_frame(80, 60, 32, 32'h0, 32'h0);
        check("R9 first frame no error", {31'b0, cfg_error}, 32'h0);
        send_frame(130, 60, 32, 32'hCAFE_F00D, 32'h0BAD_BEEF);
        check("R8 offset rule sets error", {31'b0, cfg_error}, 32'h1);
        check("R8 offset rule no strobe", 32'(vcount), 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule